// File: doc/BRIEF.md
# Delta Varint Trace Encoder

This block turns a stream of memory-access trace records, each an address and a timestamp, into a compact byte stream. For every record it forms the difference from the record before it. The address difference is a signed value: the block maps it to an unsigned code with a zigzag fold and then writes it as a variable-length integer. The time difference is unsigned and is written as a second variable-length integer straight after the first. The previous address and time carry across the whole stream. A downstream buffer flush therefore never restarts the differences.

Records enter through a valid/ready handshake. Bytes leave one per cycle through a second valid/ready handshake. The block counts the bytes it has emitted since the last flush. When that count has reached a configurable high-water level at the start of a new record, it flags the first byte of that record as a flush point. The consumer writes out everything it received before that byte.

Top module: `trace_delta_encoder`

## Requirements
- R1: The address code is d' = (d << 1) XOR (d >>> 31), where d = rec_addr − previous address, taken modulo 2^32 as a signed 32-bit value. For example, d = −2 gives 3 and d = 0x80000000 gives 0xFFFFFFFF.
- R2: The time code is rec_time − previous time, taken modulo 2^64 as an unsigned value.
- R3: Each code is emitted as a variable-length integer. Each byte carries 7 code bits in bits 6:0, least significant group first. Bit 7 is 1 on every byte except the last, and the encoding has minimum length, so a zero code is the single byte 0x00.
- R4: For each record, all bytes of the address code come before all bytes of the time code. Records are emitted in the order they were accepted.
- R5: Reset clears the previous address and time to zero, so the first record's differences equal its absolute values. After each accepted record, the previous values become that record's values, and flush points never disturb them.
- R6: rec_ready is high exactly when no byte of an earlier record is still waiting. It stays low from the acceptance of a record until the last byte of its time code has been taken.
- R7: While out_valid is high and out_ready is low, out_valid and out_byte hold their values. When out_ready is high, one byte is taken per cycle with no bubble inside a record.
- R8: out_flush is high on the first address byte of a record when the number of bytes taken since reset or since the last flagged byte is at least HIGH_WATER. The flagged byte itself counts as the first byte of the new count. out_flush is low on every other byte.
- R9: During and right after reset, out_valid and out_flush are low and rec_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record accepted on this cycle when high with rec_valid |
| rec_addr | input | ADDR_W | Record address |
| rec_time | input | TIME_W | Record timestamp |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Encoded byte |
| out_flush | output | 1 | Bytes before this one form a full batch |

## Verification
The assertions assume that the consumer follows the handshake: a byte counts as taken only in a cycle where out_valid and out_ready are both high. They also assume that rec_addr and rec_time are sampled only at acceptance. The bench drives out_ready low in about a quarter of the cycles, at random, so that stalls fall inside both codes. It changes record fields only between acceptances. The random records mix small steps, backward steps, repeats and full-range jumps of address and time, so that code lengths run from one byte to the maximum and flush points land at many offsets within records.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_TIME = 2'd2
    } trc_phase_t;

    typedef struct packed {
        logic       first;
        logic [7:0] data;
    } trc_byte_t;

    // Bytes needed by the longest varint of a w-bit code
    function automatic int unsigned vint_max_bytes(input int unsigned w);
        return (w + 6) / 7;
    endfunction

endpackage

// File: rtl/trc_delta.sv
module trc_delta #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [TIME_W-1:0] cur_time,
    output logic [ADDR_W-1:0] addr_code,
    output logic [TIME_W-1:0] time_code
);
    logic [ADDR_W-1:0] last_addr;
    logic [TIME_W-1:0] last_time;
    logic [ADDR_W-1:0] addr_diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            last_time <= '0;
        end else if (take) begin
            last_addr <= cur_addr;
            last_time <= cur_time;
        end
    end

    always_comb begin
        addr_diff = cur_addr - last_addr;
        addr_code = {addr_diff[ADDR_W-2:0], 1'b0} ^ {ADDR_W{addr_diff[ADDR_W-1]}};
        time_code = cur_time - last_time;
    end

endmodule

// File: rtl/trc_varint_ser.sv
module trc_varint_ser
    import trc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_code,
    input  logic [TIME_W-1:0] time_code,
    input  logic              fire,
    output logic              busy,
    output trc_byte_t         beat
);
    localparam int unsigned PAD_W = TIME_W - ADDR_W;

    trc_phase_t        phase;
    logic [TIME_W-1:0] work;
    logic [TIME_W-1:0] pend_time;
    logic              at_first;
    logic              more;

    assign more       = |work[TIME_W-1:7];
    assign busy       = (phase != PH_IDLE);
    assign beat.first = at_first;
    assign beat.data  = {more, work[6:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            work      <= '0;
            pend_time <= '0;
            at_first  <= 1'b0;
        end else if (load) begin
            phase     <= PH_ADDR;
            work      <= {{PAD_W{1'b0}}, addr_code};
            pend_time <= time_code;
            at_first  <= 1'b1;
        end else if (fire) begin
            at_first <= 1'b0;
            if (more) begin
                work <= work >> 7;
            end else if (phase == PH_ADDR) begin
                work  <= pend_time;
                phase <= PH_TIME;
            end else begin
                phase <= PH_IDLE;
            end
        end
    end

    AST_ADDR_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |-> (work[TIME_W-1:ADDR_W] == '0)); // R3

    AST_FIRST_IS_ADDR: assert property (@(posedge clk) disable iff (rst)
        at_first |-> (phase == PH_ADDR)); // R4

endmodule

// File: rtl/trc_fill_ctr.sv
module trc_fill_ctr #(
    parameter int unsigned HIGH_WATER = 16,
    parameter int unsigned REC_MAX    = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic first,
    input  logic valid,
    input  logic fire,
    output logic flush
);
    localparam int unsigned CNT_MAX = HIGH_WATER + REC_MAX;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] fill;

    assign flush = valid && first && (fill >= CNT_W'(HIGH_WATER));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (fire) begin
            fill <= flush ? CNT_W'(1) : fill + CNT_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(CNT_MAX - 1)); // R8

    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (rst)
        (fire && flush) |=> (fill == CNT_W'(1))); // R8

endmodule

// File: rtl/trace_delta_encoder.sv
module trace_delta_encoder
    import trc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned TIME_W     = 64,
    parameter int unsigned HIGH_WATER = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [TIME_W-1:0] rec_time,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_flush
);
    localparam int unsigned REC_MAX = vint_max_bytes(ADDR_W) + vint_max_bytes(TIME_W);

    logic              take;
    logic              fire;
    logic              busy;
    logic [ADDR_W-1:0] addr_code;
    logic [TIME_W-1:0] time_code;
    trc_byte_t         beat;

    assign rec_ready = !busy;
    assign take      = rec_valid && rec_ready;
    assign out_valid = busy;
    assign out_byte  = beat.data;
    assign fire      = out_valid && out_ready;

    trc_delta #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_delta (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .cur_addr  (rec_addr),
        .cur_time  (rec_time),
        .addr_code (addr_code),
        .time_code (time_code)
    );

    trc_varint_ser #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .addr_code (addr_code),
        .time_code (time_code),
        .fire      (fire),
        .busy      (busy),
        .beat      (beat)
    );

    trc_fill_ctr #(.HIGH_WATER(HIGH_WATER), .REC_MAX(REC_MAX)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .first (beat.first),
        .valid (out_valid),
        .fire  (fire),
        .flush (out_flush)
    );

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R7

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !rec_ready); // R6

    AST_FLUSH_QUAL: assert property (@(posedge clk) disable iff (rst)
        out_flush |-> out_valid); // R8

    AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
        take |=> (out_valid && !rec_ready)); // R6

endmodule

// File: tb/tb_trace_delta_encoder.sv
module tb_trace_delta_encoder;
    localparam int CLK_P = 10;
    localparam int HW    = 16;
    localparam int NREC  = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [31:0] rec_addr = '0;
    logic [63:0] rec_time = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        out_flush;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    logic [31:0] m_pa = '0;
    logic [63:0] m_pt = '0;
    int m_cnt = 0;
    bit ready_bias = 1'b1;

    trace_delta_encoder #(.HIGH_WATER(HW)) dut (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_addr(rec_addr), .rec_time(rec_time), .out_valid(out_valid),
        .out_ready(out_ready), .out_byte(out_byte), .out_flush(out_flush)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] zz(input logic [31:0] d);
        return {d[30:0], 1'b0} ^ {32{d[31]}};
    endfunction

    task automatic push_code(input logic [63:0] v, input bit rec_start);
        logic [63:0] x = v;
        bit f = rec_start;
        do begin
            logic [7:0] b;
            bit fl;
            b[6:0] = x[6:0];
            x = x >> 7;
            b[7] = (x != 0);
            fl = f && (m_cnt >= HW);
            m_cnt = fl ? 1 : m_cnt + 1;
            exp_q.push_back({fl, b});
            f = 1'b0;
        end while (x != 0);
    endtask

    task automatic send(input logic [31:0] a, input logic [63:0] t);
        @(negedge clk);
        rec_valid = 1'b1;
        rec_addr  = a;
        rec_time  = t;
        while (!rec_ready) @(negedge clk);
        push_code({32'd0, zz(a - m_pa)}, 1'b1);   // R1, R4, R5
        push_code(t - m_pt, 1'b0);               // R2
        m_pa = a;
        m_pt = t;
        @(posedge clk);
        #1 rec_valid = 1'b0;
    endtask

    // Consumer: drive ready, sample before the next edge
    initial begin
        bit stall_prev = 1'b0;
        logic [7:0] stall_byte = '0;
        forever begin
            @(negedge clk);
            out_ready = ready_bias ? (($urandom % 4) != 0) : 1'b0;
            #1;
            if (!rst) begin
                if (stall_prev)
                    check(out_valid && out_byte == stall_byte, "R7 hold", {55'd0, out_valid, out_byte}, {56'd1, stall_byte});
                if (out_valid)
                    check(!rec_ready, "R6 ready low while busy", 64'(rec_ready), 64'd0);
                if (out_valid && out_ready) begin
                    logic [8:0] e;
                    if (exp_q.size() == 0) e = 9'h1FF; else e = exp_q.pop_front();
                    check({out_flush, out_byte} == e, "R3/R4/R8 byte", {55'd0, out_flush, out_byte}, {55'd0, e});
                end
                stall_prev = out_valid && !out_ready;
                stall_byte = out_byte;
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic drain;
        int guard = 0;
        while ((exp_q.size() != 0 || !rec_ready) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && !out_flush && rec_ready, "R9 reset state", {61'd0, out_valid, out_flush, rec_ready}, 64'd1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid && rec_ready, "R9 after reset", {62'd0, out_valid, rec_ready}, 64'd1);

        // R5 first record is absolute: 5 -> 0x0A, 100 -> 0x64
        send(32'd5, 64'd100);
        // zero deltas: 0x00 0x00 (R3 minimum length)
        send(32'd5, 64'd100);
        // R1 delta -2 -> code 3; time +128 -> 0x80 0x01
        send(32'd3, 64'd228);
        // R1 extreme signed delta, R2 wrap to all ones
        send(32'h8000_0003, 64'd227);
        send(32'h0000_0003, 64'd227);
        drain();
        check(exp_q.size() == 0, "R4 all bytes out", 64'(exp_q.size()), 64'd0);

        // R7 long stall
        ready_bias = 1'b0;
        send(32'h1234_5678, 64'h0000_0100_0000_0000);
        repeat (6) @(negedge clk);
        ready_bias = 1'b1;
        drain();

        for (int i = 0; i < NREC; i++) begin
            logic [31:0] a;
            logic [63:0] t;
            case ($urandom % 6)
                0: a = m_pa;
                1: a = m_pa + ($urandom % 64);
                2: a = m_pa - ($urandom % 300);
                default: a = $urandom;
            endcase
            case ($urandom % 5)
                0: t = m_pt;
                1: t = m_pt + ($urandom % 200);
                2: t = {$urandom, $urandom};
                3: t = m_pt - 1;
                default: t = m_pt + 64'($urandom % 100000);
            endcase
            send(a, t);
        end
        drain();
        check(exp_q.size() == 0 && rec_ready, "R6 idle at end", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule